// File: doc/BRIEF.md
# SMBus Controller Control/Status Register Bank with Interrupt Aggregation

This block is the software-facing side of an SMBus/I2C controller. Through a byte-wide register port, software writes a control byte and reads back both the control byte and a status byte. A separate bit-level engine, which is not part of this block, drives SCL and SDA. That engine reports bus events to this block as one-cycle pulses: address match, bus error, negative acknowledge, data ready, start completed and slave-mode stop. In return it receives request and enable levels from this block: start request, stop request, NACK-next, stall-after-start and general-call enable.

A small request state machine owns the START and STOP control bits. It has three states:

- `REQ_IDLE`: no request is pending.
- `REQ_START`: a start request is held.
- `REQ_STOP`: a stop request is held.

It has these transitions:

- Writing STOP moves it to `REQ_STOP` from `REQ_IDLE` or `REQ_START`. STOP is honoured before START when both are written at once.
- Writing START while idle moves it from `REQ_IDLE` to `REQ_START`.
- The engine's start-done pulse returns it from `REQ_START` to `REQ_IDLE`.
- The engine's stop-done pulse returns it from `REQ_STOP` to `REQ_IDLE`.
- Disabling the controller forces `REQ_IDLE` from any state.

Status flags are sticky and are cleared by writing 1 to them. A single registered interrupt line combines the flags, and each flag is qualified by its own enable.

Top module: `smb_ctl_regs`

## Requirements
- R1: After reset the control byte (offset 3) and status byte (offset 1) both read 00h, and start_req_o, stop_req_o, nack_next_o, stall_en_o, gcall_en_o and irq_o are all 0.
- R2: The control byte has this bit layout:
  - bit 7: stall-after-start enable
  - bit 6: new-match interrupt enable
  - bit 5: general-call enable
  - bit 4: NACK-next
  - bit 3: reserved
  - bit 2: interrupt enable
  - bit 1: STOP
  - bit 0: START

  A write to offset 3 stores bits 7, 6, 5, 4 and 2, and they read back unchanged. Bit 3 always reads 0. Bit 7 drives stall_en_o and bit 5 drives gcall_en_o. Offsets 0 and 2 read 00h.
- R3: While enable_i is 0, every control bit is held at 0, writes to offset 3 are ignored, and any pending start or stop request is dropped.
- R4: START and STOP are governed by the request state machine:
  - Writing bit 0 while idle raises start_req_o.
  - Writing bit 1 raises stop_req_o from idle or from start-pending, and drops start_req_o.
  - START writes are ignored while a stop is pending.
  - start_done_i and stop_done_i return the machine to idle.
  - Bits 0 and 1 read back the pending requests.
- R5: nack_next_o equals control bit 4 while tx_mode_i is 0, and is 0 while tx_mode_i is 1. ack_done_i clears bit 4.
- R6: The status byte at offset 1 has these bits:
  - bit 7: slave stop
  - bit 6: data ready
  - bit 5: bus error
  - bit 4: negative acknowledge
  - bit 3: start-stall
  - bit 2: new match

  Each bit is set by its event pulse and stays set. Writing 1 to the bit clears it, writing 0 leaves it, and a set pulse in the same cycle as a clear write leaves the bit set. Bits 1:0 read 0.
- R7: The start-stall flag is set by ev_start_ok_i only while control bit 7 is 1. Clearing bit 7 does not clear a flag that is already set.
- R8: irq_o is registered. It rises one cycle after a qualifying flag and enable are both present, and it is 0 whenever interrupt enable (bit 2) was 0 in the previous cycle.
- R9: These conditions qualify for the interrupt:
  - new match, only with bit 6 set
  - data ready, only while dma_on_i is 0
  - start-stall, only with master_i and bit 7 both set
  - bus error, negative acknowledge and slave stop, always
- R10: irq_o falls one cycle after the last qualifying flag is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Controller enable; 0 clears the control byte |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register offset |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i (combinational) |
| ev_match_i | input | 1 | Address-match pulse |
| ev_buserr_i | input | 1 | Bus-error pulse |
| ev_nack_i | input | 1 | Negative-acknowledge-received pulse |
| ev_ready_i | input | 1 | Data-ready pulse |
| ev_start_ok_i | input | 1 | Start-completed pulse |
| ev_slvstop_i | input | 1 | Stop-in-slave-mode pulse |
| start_done_i | input | 1 | Engine has issued the start |
| stop_done_i | input | 1 | Engine has issued the stop |
| ack_done_i | input | 1 | Acknowledge cycle finished |
| master_i | input | 1 | Engine is in master mode |
| tx_mode_i | input | 1 | Engine is transmitting |
| dma_on_i | input | 1 | DMA transfer active |
| start_req_o | output | 1 | Start request level |
| stop_req_o | output | 1 | Stop request level |
| nack_next_o | output | 1 | Send NACK on the next received byte |
| stall_en_o | output | 1 | Stall bus after address byte |
| gcall_en_o | output | 1 | Respond to general call |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench sweeps every combination of the six status flags against every combination of interrupt enable, new-match enable, DMA, master mode and stall enable. It then compares irq_o with the value computed in the bench. A design that drops a gating term would fire the interrupt on a masked match or on data ready during DMA, and a design that adds a gating term would miss it. Explicit cases cover a set pulse coinciding with a clear write, which a clear-priority design would lose, and the start-stall flag surviving the removal of its enable. They also cover the request machine, which would wrongly honour a START written while a stop is pending. The one-cycle interrupt latency on both edges is sampled directly, which catches a combinational or doubly registered output.

// File: rtl/smb_ctl_pkg.sv
package smb_ctl_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_EVT = 6;
    localparam int EVT_LSB = 2;

    // control byte bit positions
    localparam int CB_STALL_EN = 7;
    localparam int CB_MATCH_IE = 6;
    localparam int CB_GCALL_EN = 5;
    localparam int CB_NACK     = 4;
    localparam int CB_RSVD     = 3;
    localparam int CB_IRQ_EN   = 2;
    localparam int CB_STOP     = 1;
    localparam int CB_START    = 0;

    // bits held in the configuration register (request bits live in the FSM)
    localparam logic [DATA_W-1:0] CFG_MASK =
        DATA_W'((1 << CB_STALL_EN) | (1 << CB_MATCH_IE) | (1 << CB_GCALL_EN) |
                (1 << CB_NACK) | (1 << CB_IRQ_EN));

    // event flag indices; status bit = index + EVT_LSB
    localparam int EV_MATCH   = 0;
    localparam int EV_STALL   = 1;
    localparam int EV_NACK    = 2;
    localparam int EV_BUSERR  = 3;
    localparam int EV_READY   = 4;
    localparam int EV_SLVSTOP = 5;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_START = 2'd1,
        REQ_STOP  = 2'd2
    } req_state_e;

endpackage

// File: rtl/smb_ctl_bank.sv
module smb_ctl_bank
    import smb_ctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              start_done_i,
    input  logic              stop_done_i,
    input  logic              ack_done_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              start_req_o,
    output logic              stop_req_o
);

    logic [DATA_W-1:0] cfg_q, cfg_d;
    req_state_e        state_q, state_d;

    // configuration bits
    always_comb begin
        cfg_d = cfg_q;
        if (!enable_i) begin
            cfg_d = '0;
        end else if (we_i) begin
            cfg_d = wdata_i & CFG_MASK;
        end else if (ack_done_i) begin
            cfg_d[CB_NACK] = 1'b0;
        end
    end

    // request state machine: next state
    always_comb begin
        state_d = state_q;
        if (!enable_i) begin
            state_d = REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE: begin
                    if (we_i && wdata_i[CB_STOP])
                        state_d = REQ_STOP;
                    else if (we_i && wdata_i[CB_START])
                        state_d = REQ_START;
                end
                REQ_START: begin
                    if (we_i && wdata_i[CB_STOP])
                        state_d = REQ_STOP;
                    else if (start_done_i)
                        state_d = REQ_IDLE;
                end
                REQ_STOP: begin
                    if (stop_done_i)
                        state_d = REQ_IDLE;
                end
                default: state_d = REQ_IDLE;
            endcase
        end
    end

    // state and configuration registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= REQ_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    // request outputs
    always_comb begin
        start_req_o = 1'b0;
        stop_req_o  = 1'b0;
        unique case (state_q)
            REQ_IDLE:  ;
            REQ_START: start_req_o = 1'b1;
            REQ_STOP:  stop_req_o  = 1'b1;
            default:   ;
        endcase
    end

    assign ctrl_o = cfg_q | {{(DATA_W-2){1'b0}}, stop_req_o, start_req_o};

    a_r3_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (cfg_q == '0 && state_q == REQ_IDLE));

    a_r4_stop_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && state_q == REQ_STOP && stop_done_i) |=> state_q == REQ_IDLE);

    a_r4_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && state_q == REQ_STOP && !stop_done_i) |=> state_q == REQ_STOP);

    a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_done_i && !we_i) |=> !cfg_q[CB_NACK]);

endmodule

// File: rtl/smb_evt_flags.sv
module smb_evt_flags #(
    parameter int N = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;

        // set has priority over a write-one-to-clear in the same cycle
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                f_q <= 1'b0;
            else if (set_i[i])
                f_q <= 1'b1;
            else if (clr_i[i])
                f_q <= 1'b0;
        end

        assign flags_o[i] = f_q;

        a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[i] |=> flags_o[i]);

        a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
    end

endmodule

// File: rtl/smb_irq_agg.sv
module smb_irq_agg
    import smb_ctl_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] flags_i,
    input  logic               irq_en_i,
    input  logic               match_ie_i,
    input  logic               stall_en_i,
    input  logic               master_i,
    input  logic               dma_on_i,
    output logic               irq_o
);

    logic [NUM_EVT-1:0] src;
    logic               irq_q;

    always_comb begin
        src             = '0;
        src[EV_MATCH]   = flags_i[EV_MATCH] & match_ie_i;
        src[EV_STALL]   = flags_i[EV_STALL] & master_i & stall_en_i;
        src[EV_NACK]    = flags_i[EV_NACK];
        src[EV_BUSERR]  = flags_i[EV_BUSERR];
        src[EV_READY]   = flags_i[EV_READY] & ~dma_on_i;
        src[EV_SLVSTOP] = flags_i[EV_SLVSTOP];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            irq_q <= 1'b0;
        else
            irq_q <= irq_en_i & (|src);
    end

    assign irq_o = irq_q;

    a_r8_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |=> !irq_o);

    a_r9_buserr_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_en_i && flags_i[EV_BUSERR]) |=> irq_o);

    a_r9_ready_dma_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_on_i && flags_i == NUM_EVT'(1 << EV_READY)) |=> !irq_o);

endmodule

// File: rtl/smb_ctl_regs.sv
module smb_ctl_regs
    import smb_ctl_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CTRL_OFS = 3,
    parameter int STAT_OFS = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              ev_match_i,
    input  logic              ev_buserr_i,
    input  logic              ev_nack_i,
    input  logic              ev_ready_i,
    input  logic              ev_start_ok_i,
    input  logic              ev_slvstop_i,
    input  logic              start_done_i,
    input  logic              stop_done_i,
    input  logic              ack_done_i,
    input  logic              master_i,
    input  logic              tx_mode_i,
    input  logic              dma_on_i,
    output logic              start_req_o,
    output logic              stop_req_o,
    output logic              nack_next_o,
    output logic              stall_en_o,
    output logic              gcall_en_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic               ctrl_sel, stat_sel;
    logic [DATA_W-1:0]  ctrl;
    logic [NUM_EVT-1:0] ev_set, ev_clr, flags;
    logic               unused_ok;

    assign ctrl_sel  = (addr_i == CTRL_A);
    assign stat_sel  = (addr_i == STAT_A);
    assign unused_ok = &{1'b0, wr_data_i[EVT_LSB-1:0]};

    smb_ctl_bank u_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enable_i     (enable_i),
        .we_i         (wr_en_i & ctrl_sel),
        .wdata_i      (wr_data_i),
        .start_done_i (start_done_i),
        .stop_done_i  (stop_done_i),
        .ack_done_i   (ack_done_i),
        .ctrl_o       (ctrl),
        .start_req_o  (start_req_o),
        .stop_req_o   (stop_req_o)
    );

    always_comb begin
        ev_set             = '0;
        ev_set[EV_MATCH]   = ev_match_i;
        ev_set[EV_STALL]   = ev_start_ok_i & ctrl[CB_STALL_EN];
        ev_set[EV_NACK]    = ev_nack_i;
        ev_set[EV_BUSERR]  = ev_buserr_i;
        ev_set[EV_READY]   = ev_ready_i;
        ev_set[EV_SLVSTOP] = ev_slvstop_i;
    end

    assign ev_clr = {NUM_EVT{wr_en_i & stat_sel}} & wr_data_i[DATA_W-1:EVT_LSB];

    smb_evt_flags #(.N(NUM_EVT)) u_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (ev_set),
        .clr_i   (ev_clr),
        .flags_o (flags)
    );

    smb_irq_agg u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flags_i    (flags),
        .irq_en_i   (ctrl[CB_IRQ_EN]),
        .match_ie_i (ctrl[CB_MATCH_IE]),
        .stall_en_i (ctrl[CB_STALL_EN]),
        .master_i   (master_i),
        .dma_on_i   (dma_on_i),
        .irq_o      (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (ctrl_sel)
            rd_data_o = ctrl;
        else if (stat_sel)
            rd_data_o = {flags, {EVT_LSB{1'b0}}};
    end

    assign nack_next_o = ctrl[CB_NACK] & ~tx_mode_i;
    assign stall_en_o  = ctrl[CB_STALL_EN];
    assign gcall_en_o  = ctrl[CB_GCALL_EN];

    a_r7_stall_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stall_en_o && !flags[EV_STALL]) |=> !flags[EV_STALL]);

    a_r7_stall_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags[EV_STALL] && !(wr_en_i && stat_sel && wr_data_i[EV_STALL+EVT_LSB]))
            |=> flags[EV_STALL]);

    a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_sel |-> !rd_data_o[CB_RSVD]);

endmodule

// File: tb/smb_ctl_regs_tb_top.sv
module smb_ctl_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_data;
    logic       ev_match = 1'b0, ev_buserr = 1'b0, ev_nack = 1'b0;
    logic       ev_ready = 1'b0, ev_start_ok = 1'b0, ev_slvstop = 1'b0;
    logic       start_done = 1'b0, stop_done = 1'b0, ack_done = 1'b0;
    logic       master = 1'b0, tx_mode = 1'b0, dma_on = 1'b0;
    logic       start_req, stop_req, nack_next, stall_en, gcall_en, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smb_ctl_regs dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data),
        .ev_match_i(ev_match), .ev_buserr_i(ev_buserr), .ev_nack_i(ev_nack),
        .ev_ready_i(ev_ready), .ev_start_ok_i(ev_start_ok), .ev_slvstop_i(ev_slvstop),
        .start_done_i(start_done), .stop_done_i(stop_done), .ack_done_i(ack_done),
        .master_i(master), .tx_mode_i(tx_mode), .dma_on_i(dma_on),
        .start_req_o(start_req), .stop_req_o(stop_req), .nack_next_o(nack_next),
        .stall_en_o(stall_en), .gcall_en_o(gcall_en), .irq_o(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    // event order: {slvstop, ready, buserr, nack, start_ok, match}
    task automatic pulse_ev(input logic [5:0] m);
        {ev_slvstop, ev_ready, ev_buserr, ev_nack, ev_start_ok, ev_match} = m;
        @(negedge clk);
        {ev_slvstop, ev_ready, ev_buserr, ev_nack, ev_start_ok, ev_match} = 6'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd3, d); chk("R1", "ctrl after reset", d, 8'h00);
        rd(2'd1, d); chk("R1", "status after reset", d, 8'h00);
        chk("R1", "outputs after reset",
            {start_req, stop_req, nack_next, stall_en, gcall_en, irq}, 0);
        enable = 1'b1;
        tick();

        // R2 stored bits, reserved bit and unused offsets
        for (int v = 0; v < 64; v++) begin
            wr(2'd3, 8'(v << 2));
            rd(2'd3, d);
            chk("R2", "ctrl readback", d, (v << 2) & 8'hF4);
            chk("R2", "stall/gcall out", {stall_en, gcall_en}, {v[5], v[3]});
        end
        wr(2'd3, 8'hFC);
        rd(2'd0, d); chk("R2", "offset 0", d, 0);
        rd(2'd2, d); chk("R2", "offset 2", d, 0);

        // R3 disable clears and blocks writes
        wr(2'd3, 8'hF5);
        chk("R3", "start before disable", start_req, 1);
        enable = 1'b0;
        tick();
        rd(2'd3, d); chk("R3", "ctrl disabled", d, 0);
        chk("R3", "start dropped", start_req, 0);
        wr(2'd3, 8'hF6);
        rd(2'd3, d); chk("R3", "write while disabled", d, 0);
        chk("R3", "outputs disabled", {stop_req, stall_en, gcall_en}, 0);
        enable = 1'b1;
        tick();
        rd(2'd3, d); chk("R3", "ctrl after re-enable", d, 0);

        // R4 request state machine
        wr(2'd3, 8'h01);
        rd(2'd3, d); chk("R4", "start pending readback", d, 8'h01);
        chk("R4", "start_req", {start_req, stop_req}, 2'b10);
        start_done = 1'b1; tick(); start_done = 1'b0;
        chk("R4", "start done", {start_req, stop_req}, 2'b00);
        wr(2'd3, 8'h01);
        wr(2'd3, 8'h02);
        chk("R4", "stop aborts start", {start_req, stop_req}, 2'b01);
        wr(2'd3, 8'h01);
        chk("R4", "start ignored in stop", {start_req, stop_req}, 2'b01);
        rd(2'd3, d); chk("R4", "stop readback", d, 8'h02);
        start_done = 1'b1; tick(); start_done = 1'b0;
        chk("R4", "start_done ignored in stop", stop_req, 1);
        stop_done = 1'b1; tick(); stop_done = 1'b0;
        chk("R4", "stop done", {start_req, stop_req}, 2'b00);
        wr(2'd3, 8'h03);
        chk("R4", "stop priority", {start_req, stop_req}, 2'b01);
        stop_done = 1'b1; tick(); stop_done = 1'b0;

        // R5 NACK-next
        wr(2'd3, 8'h10);
        tx_mode = 1'b1; #1;
        chk("R5", "nack in tx", nack_next, 0);
        tx_mode = 1'b0; #1;
        chk("R5", "nack in rx", nack_next, 1);
        ack_done = 1'b1; tick(); ack_done = 1'b0;
        rd(2'd3, d); chk("R5", "ack bit cleared", d, 8'h00);
        chk("R5", "nack after ack", nack_next, 0);

        // R6 sticky flags and write-one-to-clear
        wr(2'd3, 8'h80);
        pulse_ev(6'h3F);
        rd(2'd1, d); chk("R6", "all flags", d, 8'hFC);
        wr(2'd1, 8'h04);
        rd(2'd1, d); chk("R6", "w1c match", d, 8'hF8);
        wr(2'd1, 8'h03);
        rd(2'd1, d); chk("R6", "w0 no effect", d, 8'hF8);
        wr_en = 1'b1; addr = 2'd1; wdata = 8'h20; ev_buserr = 1'b1;
        tick();
        wr_en = 1'b0; wdata = 8'h00; ev_buserr = 1'b0;
        rd(2'd1, d); chk("R6", "set beats clear", d, 8'hF8);
        wr(2'd1, 8'hFC);
        rd(2'd1, d); chk("R6", "all cleared", d, 8'h00);

        // R7 start-stall gating
        wr(2'd3, 8'h00);
        pulse_ev(6'h02);
        rd(2'd1, d); chk("R7", "stall blocked", d, 8'h00);
        wr(2'd3, 8'h80);
        pulse_ev(6'h02);
        rd(2'd1, d); chk("R7", "stall set", d, 8'h08);
        wr(2'd3, 8'h00);
        rd(2'd1, d); chk("R7", "stall kept", d, 8'h08);
        wr(2'd1, 8'hFC);

        // R8/R10 interrupt latency
        wr(2'd3, 8'h04);
        pulse_ev(6'h04);
        chk("R8", "irq not yet", irq, 0);
        tick();
        chk("R8", "irq one cycle later", irq, 1);
        wr(2'd1, 8'h20);
        tick();
        chk("R10", "irq kept on other clear", irq, 1);
        wr(2'd1, 8'h10);
        chk("R10", "irq before drop", irq, 1);
        tick();
        chk("R10", "irq dropped", irq, 0);
        pulse_ev(6'h08);
        tick();
        wr(2'd3, 8'h00);
        chk("R10", "irq before enable off", irq, 1);
        tick();
        chk("R10", "irq off with enable", irq, 0);
        wr(2'd1, 8'hFC);

        // R9 sweep: flags x (irq_en, match_ie, dma, master, stall_en)
        for (int m = 0; m < 64; m++) begin
            for (int c = 0; c < 32; c++) begin
                logic exp_irq;
                wr(2'd1, 8'hFC);
                wr(2'd3, 8'h80);
                pulse_ev(6'(m));
                dma_on = c[2];
                master = c[3];
                wr(2'd3, {c[4], c[1], 3'b000, c[0], 2'b00});
                tick(); tick();
                exp_irq = c[0] & ((m[0] & c[1]) | (m[1] & c[3] & c[4]) | m[2] | m[3] |
                                  (m[4] & ~c[2]) | m[5]);
                chk("R9", $sformatf("irq m=%0h c=%0h", m, c), irq, exp_irq);
                if (c == 0) begin
                    rd(2'd1, d);
                    chk("R6", $sformatf("status m=%0h", m), d, m << 2);
                end
            end
        end
        dma_on = 1'b0; master = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule